// File: doc/BRIEF.md
# External Memory Word Packing Interface

This block connects an internal requester to an asynchronous external memory bus. A single internal access carries either a 16-bit or a 24-bit word. The block splits that word into the pieces the external data path can carry, and runs one external bus cycle for each piece. The external data path is sixteen lines wide and can be run as an 8-bit or a 16-bit bus. Pieces are ordered little-endian: the lowest byte or halfword goes to the base address, and each further piece goes to the next consecutive external address.

When the bus runs 8 bits wide, the upper eight data lines are not needed for memory traffic. They are handed back as eight general-purpose bidirectional flag pins, and each pin has its own direction control. When the bus runs 16 bits wide, the flag function is switched off and those lines carry data.

The internal port uses a request/acknowledge handshake. The requester holds `req_valid` and the request fields steady until `req_ack` pulses, and then drops `req_valid` in that same cycle. The bus mode input `cfg_bus8` must stay steady while an access is in flight.

The sequencer has four states:
- **IDLE** waits for a request.
- **STROBE** holds chip select and either the read or the write strobe low until the external acknowledge is sampled high.
- **GAP** is one clock with every strobe released.
- **DONE** drives the one-clock internal acknowledge.

Its transitions are:
- IDLE→STROBE when a request is accepted.
- STROBE→STROBE while the acknowledge is low.
- STROBE→GAP when the acknowledge is high and more pieces remain.
- STROBE→DONE when the acknowledge is high on the last piece.
- GAP→STROBE, with the piece index advanced.
- DONE→IDLE.

Top module: `xmem_pack_if`

## Requirements
- R1: After reset, `ext_cs_n`, `ext_rd_n` and `ext_wr_n` are high, `req_ack` is low, and `ext_oe_lo` is low.
- R2: The number of external cycles per access is fixed by the mode:
  - 8-bit bus (`cfg_bus8`=1): 2 cycles for a 16-bit word (`req_wide`=0) and 3 cycles for a 24-bit word (`req_wide`=1).
  - 16-bit bus: 1 cycle for a 16-bit word and 2 cycles for a 24-bit word.
- R3: Piece i of an access is placed on `ext_addr` = `req_addr`+i, modulo 2^22. The address is held steady while the strobe waits. Piece 0 carries the least significant bits.
  - On an 8-bit write, piece i drives `req_wdata` bits [8i+7:8i] on `ext_dout_lo`.
  - On a 16-bit-bus write, piece 0 drives bits [7:0] on the low lane and bits [15:0]'s upper byte [15:8] on the high lane.
- R4: On a 16-bit bus, the second piece of a 24-bit access carries `req_wdata`[23:16] on the low lane.
  - On a write, the high lane is driven as zero.
  - On a read, the high lane is ignored.
  - `req_rdata`[23:16] is zero for a 16-bit read.
- R5: Chip select and the active strobe stay low while `ext_ack` is low. With W wait clocks, each external cycle lasts W+1 clocks.
- R6: Between two external cycles of the same access, `ext_cs_n`, `ext_rd_n` and `ext_wr_n` are all high for exactly one clock.
- R7: `req_ack` is high for exactly one clock. It rises in the clock after the final external cycle samples `ext_ack` high.
- R8: Read data is assembled into `req_rdata`:
  - On the 8-bit bus, byte i comes from the low lane of piece i.
  - On the 16-bit bus, piece 0 fills bits [15:0] as {high lane, low lane], and piece 1 fills bits [23:16] from its low lane.
- R9: With `cfg_bus8`=1, `ext_oe_hi` equals `flag_dir` (bit = 1 means output), `ext_dout_hi` equals `flag_out`, and `flag_in` equals `ext_din_hi`. This holds at all times, including during accesses.
- R10: With `cfg_bus8`=0, `flag_dir` has no effect, and `flag_in` reads zero.
  - `ext_oe_hi` is all ones during a write strobe and all zeros otherwise.
- R11: `ext_cs_n` is low exactly when one of `ext_rd_n` or `ext_wr_n` is low; the two are never low together. `ext_oe_lo` is high only during a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bus8 | input | 1 | 1 selects the 8-bit bus and flag pins; 0 selects the 16-bit bus |
| req_valid | input | 1 | Internal request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wide | input | 1 | 1 for a 24-bit word, 0 for a 16-bit word |
| req_addr | input | 22 | Base external address |
| req_wdata | input | 24 | Write word |
| req_ack | output | 1 | One-clock completion pulse |
| req_rdata | output | 24 | Assembled read word, valid while `req_ack` is high |
| ext_addr | output | 22 | External address |
| ext_cs_n | output | 1 | Chip select, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_ack | input | 1 | External cycle acknowledge |
| ext_dout_lo | output | 8 | Low data lane output value |
| ext_oe_lo | output | 1 | Low data lane output enable |
| ext_din_lo | input | 8 | Low data lane pin value |
| ext_dout_hi | output | 8 | High lane output value (data or flags) |
| ext_oe_hi | output | 8 | High lane per-bit output enable |
| ext_din_hi | input | 8 | High lane pin value |
| flag_out | input | 8 | Flag output values for the 8-bit mode |
| flag_dir | input | 8 | Flag directions for the 8-bit mode, 1 = output |
| flag_in | output | 8 | Flag pin values, zero in the 16-bit mode |

## Verification
The bench's memory model raises `ext_ack` W clocks into each strobe. A request presented before clock edge E0 therefore produces `req_ack` in the clock after edge E0 + n(W+2) − 1, where n is the piece count. The bench counts falling edges from the request and expects the acknowledge on exactly the n(W+2)-th one, and expects it to be low again on the next. Each piece's address, lane data and enables are captured on the falling edge where the model raises its acknowledge, which is the last clock of that strobe. Assembled read data is sampled in the `req_ack` clock. The flag pins are pure combinational paths, so they are checked in the same idle clock in which their inputs change.

// File: rtl/xmem_pack_pkg.sv
package xmem_pack_pkg;

    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_STROBE = 2'd1,
        XS_GAP    = 2'd2,
        XS_DONE   = 2'd3
    } xs_state_e;

    // Number of external cycles for one internal word.
    function automatic logic [1:0] piece_count(input logic bus8, input logic wide);
        logic [1:0] n;
        unique case ({bus8, wide})
            2'b00:   n = 2'd1;
            2'b01:   n = 2'd2;
            2'b10:   n = 2'd2;
            default: n = 2'd3;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pack_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             ext_ack,
    input  logic [IDX_W-1:0] pieces,
    output logic [IDX_W-1:0] idx,
    output logic             accept,
    output logic             piece_done,
    output logic             strobe_on,
    output logic             ack_out
);

    xs_state_e        state;
    xs_state_e        state_nxt;
    logic             last;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = pieces - IDX_W'(1);
    assign last     = (idx == last_idx);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= XS_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Piece index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (accept) begin
            idx <= '0;
        end else if (piece_done && !last) begin
            idx <= idx + IDX_W'(1);
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            XS_IDLE:   if (req_valid) state_nxt = XS_STROBE;
            XS_STROBE: if (ext_ack)   state_nxt = last ? XS_DONE : XS_GAP;
            XS_GAP:    state_nxt = XS_STROBE;
            XS_DONE:   state_nxt = XS_IDLE;
            default:   state_nxt = XS_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        strobe_on  = (state == XS_STROBE);
        ack_out    = (state == XS_DONE);
        accept     = (state == XS_IDLE) && req_valid;
        piece_done = strobe_on && ext_ack;
    end

endmodule

// File: rtl/xmem_lanes.sv
module xmem_lanes #(
    parameter int LANE_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic                bus8,
    input  logic                write,
    input  logic                strobe_on,
    input  logic [IDX_W-1:0]    idx,
    input  logic [3*LANE_W-1:0] wdata,
    input  logic [LANE_W-1:0]   flag_out,
    input  logic [LANE_W-1:0]   flag_dir,
    input  logic [LANE_W-1:0]   ext_din_hi,
    output logic [LANE_W-1:0]   ext_dout_lo,
    output logic                ext_oe_lo,
    output logic [LANE_W-1:0]   ext_dout_hi,
    output logic [LANE_W-1:0]   ext_oe_hi,
    output logic [LANE_W-1:0]   flag_in
);

    localparam int WORD_W = 3 * LANE_W;

    logic [LANE_W-1:0] piece_lo;
    logic [LANE_W-1:0] piece_hi;
    logic              drive_en;

    // Select the slice of the write word that belongs to the current piece
    always_comb begin
        piece_lo = '0;
        piece_hi = '0;
        if (bus8) begin
            unique case (idx)
                IDX_W'(0): piece_lo = wdata[LANE_W-1:0];
                IDX_W'(1): piece_lo = wdata[2*LANE_W-1:LANE_W];
                default:   piece_lo = wdata[WORD_W-1:2*LANE_W];
            endcase
        end else if (idx == '0) begin
            piece_lo = wdata[LANE_W-1:0];
            piece_hi = wdata[2*LANE_W-1:LANE_W];
        end else begin
            piece_lo = wdata[WORD_W-1:2*LANE_W];
            piece_hi = '0;
        end
    end

    assign drive_en    = strobe_on && write;
    assign ext_dout_lo = piece_lo;
    assign ext_oe_lo   = drive_en;

    // High lane: each pin is either a flag or a data bit, per mode
    for (genvar b = 0; b < LANE_W; b++) begin : g_hi_pin
        assign ext_dout_hi[b] = bus8 ? flag_out[b]   : piece_hi[b];
        assign ext_oe_hi[b]   = bus8 ? flag_dir[b]   : drive_en;
        assign flag_in[b]     = bus8 ? ext_din_hi[b] : 1'b0;
    end

endmodule

// File: rtl/xmem_gather.sv
module xmem_gather #(
    parameter int LANE_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                capture,
    input  logic                bus8,
    input  logic [IDX_W-1:0]    idx,
    input  logic [LANE_W-1:0]   din_lo,
    input  logic [LANE_W-1:0]   din_hi,
    output logic [3*LANE_W-1:0] rdata
);

    localparam int WORD_W = 3 * LANE_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (clear) begin
            rdata <= '0;
        end else if (capture) begin
            if (bus8) begin
                unique case (idx)
                    IDX_W'(0): rdata[LANE_W-1:0]          <= din_lo;
                    IDX_W'(1): rdata[2*LANE_W-1:LANE_W]   <= din_lo;
                    default:   rdata[WORD_W-1:2*LANE_W]   <= din_lo;
                endcase
            end else if (idx == '0) begin
                rdata[2*LANE_W-1:0] <= {din_hi, din_lo};
            end else begin
                rdata[WORD_W-1:2*LANE_W] <= din_lo;
            end
        end
    end

endmodule

// File: rtl/xmem_pack_if.sv
module xmem_pack_if
    import xmem_pack_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_bus8,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_wide,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [3*LANE_W-1:0] req_wdata,
    output logic                req_ack,
    output logic [3*LANE_W-1:0] req_rdata,
    output logic [ADDR_W-1:0]   ext_addr,
    output logic                ext_cs_n,
    output logic                ext_rd_n,
    output logic                ext_wr_n,
    input  logic                ext_ack,
    output logic [LANE_W-1:0]   ext_dout_lo,
    output logic                ext_oe_lo,
    input  logic [LANE_W-1:0]   ext_din_lo,
    output logic [LANE_W-1:0]   ext_dout_hi,
    output logic [LANE_W-1:0]   ext_oe_hi,
    input  logic [LANE_W-1:0]   ext_din_hi,
    input  logic [LANE_W-1:0]   flag_out,
    input  logic [LANE_W-1:0]   flag_dir,
    output logic [LANE_W-1:0]   flag_in
);

    localparam int WORD_W = 3 * LANE_W;
    localparam int IDX_W  = 2;

    logic [ADDR_W-1:0] base_q;
    logic [WORD_W-1:0] wdata_q;
    logic              write_q;
    logic              wide_q;
    logic [IDX_W-1:0]  pieces;
    logic [IDX_W-1:0]  idx;
    logic              accept;
    logic              piece_done;
    logic              strobe_on;

    // Capture the request when it is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            wide_q  <= 1'b0;
        end else if (accept) begin
            base_q  <= req_addr;
            wdata_q <= req_wdata;
            write_q <= req_write;
            wide_q  <= req_wide;
        end
    end

    assign pieces = piece_count(cfg_bus8, wide_q);

    xmem_seq #(.IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .ext_ack    (ext_ack),
        .pieces     (pieces),
        .idx        (idx),
        .accept     (accept),
        .piece_done (piece_done),
        .strobe_on  (strobe_on),
        .ack_out    (req_ack)
    );

    xmem_lanes #(.LANE_W(LANE_W), .IDX_W(IDX_W)) u_lanes (
        .bus8        (cfg_bus8),
        .write       (write_q),
        .strobe_on   (strobe_on),
        .idx         (idx),
        .wdata       (wdata_q),
        .flag_out    (flag_out),
        .flag_dir    (flag_dir),
        .ext_din_hi  (ext_din_hi),
        .ext_dout_lo (ext_dout_lo),
        .ext_oe_lo   (ext_oe_lo),
        .ext_dout_hi (ext_dout_hi),
        .ext_oe_hi   (ext_oe_hi),
        .flag_in     (flag_in)
    );

    xmem_gather #(.LANE_W(LANE_W), .IDX_W(IDX_W)) u_gather (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (piece_done && !write_q),
        .bus8    (cfg_bus8),
        .idx     (idx),
        .din_lo  (ext_din_lo),
        .din_hi  (ext_din_hi),
        .rdata   (req_rdata)
    );

    assign ext_addr = base_q + ADDR_W'(idx);
    assign ext_cs_n = ~strobe_on;
    assign ext_rd_n = ~(strobe_on & ~write_q);
    assign ext_wr_n = ~(strobe_on & write_q);

endmodule

// File: rtl/xmem_pack_chk.sv
module xmem_pack_chk #(
    parameter int ADDR_W = 22,
    parameter int LANE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_bus8,
    input logic              req_ack,
    input logic              ext_cs_n,
    input logic              ext_rd_n,
    input logic              ext_wr_n,
    input logic              ext_ack,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              ext_oe_lo,
    input logic [LANE_W-1:0] ext_oe_hi
);

    p_strobe_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_cs_n && !ext_ack) |=> !ext_cs_n);

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_cs_n && !ext_ack) |=> $stable(ext_addr));

    p_gap_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_cs_n && ext_ack) |=> (ext_cs_n && ext_rd_n && ext_wr_n));

    p_ack_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    p_ack_follows_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ack) |-> $past(!ext_cs_n && ext_ack));

    p_ack_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> ext_cs_n);

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));

    p_cs_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cs_n |-> (ext_rd_n && ext_wr_n));

    p_lo_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_oe_lo |-> !ext_wr_n);

    p_flag_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_bus8 && ext_wr_n) |-> (ext_oe_hi == '0));

endmodule

bind xmem_pack_if xmem_pack_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_bus8  (cfg_bus8),
    .req_ack   (req_ack),
    .ext_cs_n  (ext_cs_n),
    .ext_rd_n  (ext_rd_n),
    .ext_wr_n  (ext_wr_n),
    .ext_ack   (ext_ack),
    .ext_addr  (ext_addr),
    .ext_oe_lo (ext_oe_lo),
    .ext_oe_hi (ext_oe_hi)
);

// File: tb/xmem_pack_if_tb.sv
module xmem_pack_if_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bus8 = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [21:0] req_addr = '0;
    logic [23:0] req_wdata = '0;
    logic        req_ack;
    logic [23:0] req_rdata;
    logic [21:0] ext_addr;
    logic        ext_cs_n, ext_rd_n, ext_wr_n;
    logic        ext_ack = 1'b0;
    logic [7:0]  ext_dout_lo;
    logic        ext_oe_lo;
    logic [7:0]  ext_din_lo;
    logic [7:0]  ext_dout_hi;
    logic [7:0]  ext_oe_hi;
    logic [7:0]  ext_din_hi;
    logic [7:0]  flag_out = 8'hA5;
    logic [7:0]  flag_dir = 8'h5A;
    logic [7:0]  flag_in;
    logic [7:0]  pin_drv = 8'h3C;

    int nchk = 0;
    int nerr = 0;
    int wait_n = 0;
    int scnt = 0;
    int hi_run = 0;
    int gap_bad = 0;
    int nlog = 0;

    logic [21:0] lg_addr [0:3];
    logic [7:0]  lg_lo   [0:3];
    logic [7:0]  lg_hi   [0:3];
    logic [7:0]  lg_oehi [0:3];
    logic        lg_oelo [0:3];
    logic        lg_wr   [0:3];

    always #10 clk = ~clk;

    function automatic logic [7:0] pat_lo(input logic [21:0] a);
        return a[7:0] ^ 8'h5A ^ a[21:14];
    endfunction

    function automatic logic [7:0] pat_hi(input logic [21:0] a);
        return a[7:0] ^ 8'hC3 ^ a[15:8];
    endfunction

    assign ext_din_lo = pat_lo(ext_addr);
    assign ext_din_hi = cfg_bus8 ? pin_drv : pat_hi(ext_addr);

    xmem_pack_if u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_bus8(cfg_bus8),
        .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .req_rdata(req_rdata),
        .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_ack(ext_ack),
        .ext_dout_lo(ext_dout_lo), .ext_oe_lo(ext_oe_lo), .ext_din_lo(ext_din_lo),
        .ext_dout_hi(ext_dout_hi), .ext_oe_hi(ext_oe_hi), .ext_din_hi(ext_din_hi),
        .flag_out(flag_out), .flag_dir(flag_dir), .flag_in(flag_in)
    );

    // Memory model: acknowledges wait_n clocks into each strobe and logs the piece
    always @(negedge clk) begin
        if (!ext_cs_n) begin
            if (scnt == 0 && nlog > 0 && hi_run != 1) gap_bad++;
            hi_run = 0;
            if (scnt >= wait_n) begin
                ext_ack = 1'b1;
                if (nlog < 4) begin
                    lg_addr[nlog] = ext_addr;
                    lg_lo[nlog]   = ext_dout_lo;
                    lg_hi[nlog]   = ext_dout_hi;
                    lg_oehi[nlog] = ext_oe_hi;
                    lg_oelo[nlog] = ext_oe_lo;
                    lg_wr[nlog]   = !ext_wr_n;
                end
                nlog++;
            end else begin
                ext_ack = 1'b0;
            end
            scnt++;
        end else begin
            ext_ack = 1'b0;
            scnt = 0;
            hi_run++;
        end
    end

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_access(input logic b8, input logic wide, input logic wr,
                             input logic [21:0] a, input logic [23:0] wd, input int ws);
        int n;
        int k;
        logic [23:0] rd_got;
        logic [23:0] rd_exp;
        n = b8 ? (wide ? 3 : 2) : (wide ? 2 : 1);
        @(negedge clk);
        cfg_bus8 = b8;
        wait_n = ws;
        nlog = 0;
        gap_bad = 0;
        hi_run = 1;
        req_write = wr;
        req_wide = wide;
        req_addr = a;
        req_wdata = wd;
        req_valid = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!req_ack && k < 400);
        chk_eq("R7 ack latency", k, n * (ws + 2));
        chk_eq("R5 wait stretch via latency", k - (n - 1), n * (ws + 1) + 1);
        rd_got = req_rdata;
        req_valid = 1'b0;
        @(negedge clk);
        chk_eq("R7 ack single clock", req_ack, 0);
        chk_eq("R2 piece count", nlog, n);
        chk_eq("R6 one idle clock between cycles", gap_bad, 0);
        for (int i = 0; i < n && i < 4; i++) begin
            chk_eq("R3 piece address", lg_addr[i], 22'(a + 22'(i)));
            chk_eq("R11 strobe type", lg_wr[i], wr);
            chk_eq("R11 low lane enable", lg_oelo[i], wr);
            if (b8) begin
                chk_eq("R9 flag enables during access", lg_oehi[i], flag_dir);
                chk_eq("R9 flag values during access", lg_hi[i], flag_out);
                if (wr) chk_eq("R3 byte lane data", lg_lo[i], wd[8*i +: 8]);
            end else begin
                chk_eq("R10 high lane enable", lg_oehi[i], wr ? 8'hFF : 8'h00);
                if (wr) begin
                    if (i == 0) begin
                        chk_eq("R3 low lane piece0", lg_lo[i], wd[7:0]);
                        chk_eq("R3 high lane piece0", lg_hi[i], wd[15:8]);
                    end else begin
                        chk_eq("R4 low lane piece1", lg_lo[i], wd[23:16]);
                        chk_eq("R4 high lane zero", lg_hi[i], 8'h00);
                    end
                end
            end
        end
        if (!wr) begin
            if (b8) begin
                rd_exp = {wide ? pat_lo(22'(a + 22'd2)) : 8'h00,
                          pat_lo(22'(a + 22'd1)), pat_lo(a)};
                chk_eq("R8 read assembly bus8", rd_got, rd_exp);
            end else begin
                rd_exp = {wide ? pat_lo(22'(a + 22'd1)) : 8'h00, pat_hi(a), pat_lo(a)};
                chk_eq("R4 R8 read assembly bus16", rd_got, rd_exp);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1 cs_n after reset", ext_cs_n, 1);
        chk_eq("R1 rd_n after reset", ext_rd_n, 1);
        chk_eq("R1 wr_n after reset", ext_wr_n, 1);
        chk_eq("R1 req_ack after reset", req_ack, 0);
        chk_eq("R1 oe_lo after reset", ext_oe_lo, 0);

        // Flag pins in both modes, idle
        cfg_bus8 = 1'b1; flag_dir = 8'hF0; flag_out = 8'h96; pin_drv = 8'h3C;
        #1;
        chk_eq("R9 flag enables idle", ext_oe_hi, 8'hF0);
        chk_eq("R9 flag values idle", ext_dout_hi, 8'h96);
        chk_eq("R9 flag inputs idle", flag_in, 8'h3C);
        cfg_bus8 = 1'b0; flag_dir = 8'hFF;
        #1;
        chk_eq("R10 flag enables forced off", ext_oe_hi, 8'h00);
        chk_eq("R10 flag inputs read zero", flag_in, 8'h00);
        flag_dir = 8'h5A; flag_out = 8'hA5;

        k = 0;
        for (int b = 0; b < 2; b++)
            for (int w = 0; w < 2; w++)
                for (int d = 0; d < 2; d++)
                    for (int ws = 0; ws < 3; ws++)
                        for (int ai = 0; ai < 2; ai++) begin
                            logic [21:0] a;
                            logic [23:0] wd;
                            a  = ai ? 22'h3FFFFE : 22'(22'h000123 + 22'(k * 7));
                            wd = 24'h5A3C17 ^ {8'(k), ~8'(k), 8'(k * 3)};
                            do_access(b[0], w[0], d[0], a, wd, (ws == 2) ? 3 : ws);
                            k++;
                        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule